// File: doc/BRIEF.md
# Pseudo-ternary S-bus frame codec

This block converts between parallel channel data and a two-wire pseudo-ternary line stream. The line runs one bit per clock. Each 48-bit frame carries two 64 kbit/s bearer channels (B1, B2) and one 16 kbit/s signalling channel (D). At the line rate of 192 kbit/s, frames repeat at 4 kHz.

On transmit, the block requests a new set of channel data once per frame. It captures two B1 octets, two B2 octets, four D bits and an auxiliary overhead byte, and serialises them. A binary one is sent as silence and a binary zero is sent as a full-width mark. Marks normally alternate in polarity. Two deliberate violations mark the frame: the frame-start bit, and the first mark after the leading balance bit.

On receive, the block watches the two mark inputs for polarity violations and hunts for the frame start. Once locked, it returns each frame's channel data with a one-cycle strobe and flags any violation that appears out of place.

Top module: `sbus_frame_codec`

## Requirements
- R1: A binary one is sent with both line outputs low. A binary zero is sent as a mark: `line_pos_o` high for a positive mark, `line_neg_o` high for a negative mark. The two outputs are never high together.
- R2: Every mark takes the opposite polarity to the previous mark, except in the two cases given in R4 and R6.
- R3: Frame bit positions 0..47 are laid out as follows (octets MSB first, bit 15 of each B input first):
  - 0: frame start; 1: balance
  - 2-9: B1[15:8]; 10: E[7]; 11: D[3]; 12: A[3]; 13: Fa[2]; 14: N
  - 15-22: B2[15:8]; 23: E[6]; 24: D[2]; 25: M[1]
  - 26-33: B1[7:0]; 34: E[5]; 35: D[1]; 36: S[0]
  - 37-44: B2[7:0]; 45: E[4]; 46: D[0]; 47: balance

  Bracketed numbers are bits of `tx_aux_i`, or of `tx_d_i` for D.
- R4: Bit 0 is always a mark with the same polarity as the previous mark. The first bit 0 after reset is a negative mark.
- R5: Bit 1 is always a zero, sent as a normally alternating mark. Bit 47 is zero exactly when bits 2..46 contain an odd number of zeros.
- R6: Bit 14 is the inverse of Fa. The first mark after bit 1 takes the same polarity as the bit-1 mark.
- R7: `tx_req_o` is high only during the cycle in which bit 47 is on the line, and also during reset. Transmit inputs are captured at the clock edge that ends that cycle, and bit 0 of the new frame appears after that edge.
- R8: The receiver declares lock after three consecutive frames that have a violation at the frame-start position. `rx_lock_o` rises in the cycle after the line input carries the third such violation.
- R9: While locked, three consecutive frames without a violation at the frame-start position drop `rx_lock_o`. Two such frames do not.
- R10: While locked, at the end of each received frame, `rx_valid_o` pulses for one cycle. At the same time `rx_b1_o`, `rx_b2_o` and `rx_d_o` present that frame's data in the transmit input layout.
- R11: While locked, `rx_err_o` pulses in the cycle after a violation at any position other than the frame start or the first mark after bit 1.
- R12: During the hunt, a violation can only be taken as a frame start if at least 16 bits have passed since the previous violation. This keeps the receiver from locking onto the second violation in each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one line bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_b1_i | input | 16 | B1 octets for the next frame |
| tx_b2_i | input | 16 | B2 octets for the next frame |
| tx_d_i | input | 4 | D bits for the next frame |
| tx_aux_i | input | 8 | Overhead: [7:4] E, [3] A, [2] Fa, [1] M, [0] S |
| tx_req_o | output | 1 | Transmit inputs are captured at the end of this cycle |
| line_pos_o | output | 1 | Positive mark out |
| line_neg_o | output | 1 | Negative mark out |
| line_pos_i | input | 1 | Positive mark in |
| line_neg_i | input | 1 | Negative mark in |
| rx_b1_o | output | 16 | Received B1 octets |
| rx_b2_o | output | 16 | Received B2 octets |
| rx_d_o | output | 4 | Received D bits |
| rx_valid_o | output | 1 | Received frame strobe |
| rx_lock_o | output | 1 | Frame lock held |
| rx_err_o | output | 1 | Misplaced violation seen |

## Verification
The transmitter is looped back to the receiver, and each frame cycles through four kinds of data:
- All-ones idle frames, with only the overhead and balance bits producing marks. These show that Fa/N alone carry the frame.
- All-zero frames, where the violating mark falls on bit 2.
- Two kinds of arithmetic mixtures, which vary the position of the second violation and the parity that decides the final balance bit.

Every line bit is compared against an independent encoder model, and every received frame against what was sent. Silencing the line tests hold-over and loss of lock, and then relock. Injecting a single out-of-place violation inside an idle B2 field tests the error flag without losing lock.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int unsigned FRAME_BITS = 48;
  localparam int unsigned POS_W      = $clog2(FRAME_BITS);
  localparam int unsigned LAST_POS   = FRAME_BITS - 1;
  localparam int unsigned B1A_POS    = 2;
  localparam int unsigned B2A_POS    = 15;
  localparam int unsigned B1B_POS    = 26;
  localparam int unsigned B2B_POS    = 37;
  localparam int unsigned FA_POS     = 13;
  localparam int unsigned N_POS      = 14;
  localparam int unsigned D3_POS     = 11;
  localparam int unsigned D2_POS     = 24;
  localparam int unsigned D1_POS     = 35;
  localparam int unsigned D0_POS     = 46;

  typedef enum logic [1:0] {ST_HUNT, ST_CONFIRM, ST_LOCK} rx_state_e;

  function automatic logic [FRAME_BITS-1:0] frame_pack(
      input logic [15:0] b1, input logic [15:0] b2,
      input logic [3:0] d, input logic [7:0] aux);
    logic [FRAME_BITS-1:0] v;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      v[B1A_POS+i] = b1[15-i];
      v[B1B_POS+i] = b1[7-i];
      v[B2A_POS+i] = b2[15-i];
      v[B2B_POS+i] = b2[7-i];
    end
    v[10] = aux[7]; v[23] = aux[6]; v[34] = aux[5]; v[45] = aux[4];
    v[D3_POS] = d[3]; v[D2_POS] = d[2]; v[D1_POS] = d[1]; v[D0_POS] = d[0];
    v[12] = aux[3];
    v[FA_POS] = aux[2];
    v[N_POS] = ~aux[2];
    v[25] = aux[1];
    v[36] = aux[0];
    // closing balance: zero (mark) when marks in 2..46 are odd
    v[LAST_POS] = ~(^(~v[D0_POS:B1A_POS]));
    return v;
  endfunction
endpackage

// File: rtl/sbus_tx_framer.sv
module sbus_tx_framer
  import sbus_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] b1_i,
  input  logic [15:0] b2_i,
  input  logic [3:0]  d_i,
  input  logic [7:0]  aux_i,
  output logic        req_o,
  output logic        pos_o,
  output logic        neg_o
);
  logic [POS_W-1:0]      pos_q, nxt_pos;
  logic [FRAME_BITS-1:0] frame_q;
  logic                  last_pol_q, pend_q;
  logic                  load, bit_val, mark, pol;

  assign load    = (pos_q == POS_W'(LAST_POS));
  assign nxt_pos = load ? '0 : POS_W'(pos_q + 1'b1);
  assign req_o   = load;

  always_comb begin
    bit_val = load ? 1'b0 : frame_q[nxt_pos];
    mark    = ~bit_val;
    if (nxt_pos == '0 || pend_q) pol = last_pol_q;  // deliberate violation
    else                         pol = ~last_pol_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q      <= POS_W'(LAST_POS);
      frame_q    <= '1;
      last_pol_q <= 1'b0;
      pend_q     <= 1'b0;
      pos_o      <= 1'b0;
      neg_o      <= 1'b0;
    end else begin
      if (load) frame_q <= frame_pack(b1_i, b2_i, d_i, aux_i);
      pos_q <= nxt_pos;
      pos_o <= mark & pol;
      neg_o <= mark & ~pol;
      if (mark && nxt_pos != '0) last_pol_q <= pol;
      if (nxt_pos == POS_W'(1)) pend_q <= 1'b1;
      else if (mark)            pend_q <= 1'b0;
    end
  end

  // R1
  no_double_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pos_o && neg_o));
  // R7
  req_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  // R4
  start_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> (pos_o || neg_o));
endmodule

// File: rtl/sbus_rx_deframer.sv
module sbus_rx_deframer
  import sbus_pkg::*;
#(
  parameter int unsigned LOCK_HITS   = 3,
  parameter int unsigned LOSS_MISSES = 3,
  parameter int unsigned GAP_MIN     = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pos_i,
  input  logic        neg_i,
  output logic [15:0] b1_o,
  output logic [15:0] b2_o,
  output logic [3:0]  d_o,
  output logic        valid_o,
  output logic        lock_o,
  output logic        err_o
);
  localparam int unsigned CNT_MAX = (LOCK_HITS > LOSS_MISSES) ? LOCK_HITS : LOSS_MISSES;
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);
  localparam int unsigned GW      = $clog2(GAP_MIN + 1);

  rx_state_e             state_q;
  logic [POS_W-1:0]      rpos_q;
  logic [CW-1:0]         cnt_q;
  logic [GW-1:0]         gap_q;
  logic                  seen_q, last_pol_q, pend_q;
  logic [FRAME_BITS-1:0] fv_q;
  logic                  mark, viol, cand, at_start;
  logic [15:0]           ext_b1, ext_b2;
  logic [3:0]            ext_d;

  assign mark     = pos_i | neg_i;
  assign viol     = mark && seen_q && (pos_i == last_pol_q);
  assign cand     = viol && (gap_q == GW'(GAP_MIN));
  assign at_start = (rpos_q == '0);
  assign lock_o   = (state_q == ST_LOCK);

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      ext_b1[15-i] = fv_q[B1A_POS+i];
      ext_b1[7-i]  = fv_q[B1B_POS+i];
      ext_b2[15-i] = fv_q[B2A_POS+i];
      ext_b2[7-i]  = fv_q[B2B_POS+i];
    end
    ext_d = {fv_q[D3_POS], fv_q[D2_POS], fv_q[D1_POS], fv_q[D0_POS]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_HUNT;
      rpos_q     <= '0;
      cnt_q      <= '0;
      gap_q      <= '0;
      seen_q     <= 1'b0;
      last_pol_q <= 1'b0;
      pend_q     <= 1'b0;
      fv_q       <= '1;
      b1_o       <= '0;
      b2_o       <= '0;
      d_o        <= '0;
      valid_o    <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= (state_q == ST_LOCK) && viol && !at_start && !pend_q;
      if (mark && !seen_q)       gap_q <= '0;  // restart spacing at first mark
      else if (viol)             gap_q <= '0;
      else if (gap_q < GW'(GAP_MIN)) gap_q <= gap_q + 1'b1;
      if (mark) begin
        last_pol_q <= pos_i;
        seen_q     <= 1'b1;
      end
      if (state_q == ST_HUNT) begin
        if (cand) begin
          state_q <= ST_CONFIRM;
          rpos_q  <= POS_W'(1);
          cnt_q   <= CW'(1);
          pend_q  <= 1'b0;
        end
      end else begin
        rpos_q <= (rpos_q == POS_W'(LAST_POS)) ? '0 : POS_W'(rpos_q + 1'b1);
        fv_q[rpos_q] <= ~mark;
        if (rpos_q == POS_W'(1)) pend_q <= 1'b1;
        else if (mark)           pend_q <= 1'b0;
        if (state_q == ST_LOCK && rpos_q == POS_W'(LAST_POS)) begin
          valid_o <= 1'b1;
          b1_o    <= ext_b1;
          b2_o    <= ext_b2;
          d_o     <= ext_d;
        end
        if (at_start) begin
          if (state_q == ST_CONFIRM) begin
            if (!viol) begin
              state_q <= ST_HUNT;
              cnt_q   <= '0;
            end else if (cnt_q == CW'(LOCK_HITS - 1)) begin
              state_q <= ST_LOCK;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end else begin
            if (viol) cnt_q <= '0;
            else if (cnt_q == CW'(LOSS_MISSES - 1)) begin
              state_q <= ST_HUNT;
              cnt_q   <= '0;
              seen_q  <= 1'b0;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  // R8
  lock_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(state_q == ST_CONFIRM));
  // R10
  valid_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(state_q == ST_LOCK));
  // R11
  err_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(state_q == ST_LOCK));
  // R12
  hunt_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONFIRM && $past(state_q == ST_HUNT)) |-> $past(viol && gap_q == GW'(GAP_MIN)));
endmodule

// File: rtl/sbus_frame_codec.sv
module sbus_frame_codec
  import sbus_pkg::*;
#(
  parameter int unsigned LOCK_HITS   = 3,
  parameter int unsigned LOSS_MISSES = 3,
  parameter int unsigned GAP_MIN     = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] tx_b1_i,
  input  logic [15:0] tx_b2_i,
  input  logic [3:0]  tx_d_i,
  input  logic [7:0]  tx_aux_i,
  output logic        tx_req_o,
  output logic        line_pos_o,
  output logic        line_neg_o,
  input  logic        line_pos_i,
  input  logic        line_neg_i,
  output logic [15:0] rx_b1_o,
  output logic [15:0] rx_b2_o,
  output logic [3:0]  rx_d_o,
  output logic        rx_valid_o,
  output logic        rx_lock_o,
  output logic        rx_err_o
);
  sbus_tx_framer u_tx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .b1_i  (tx_b1_i),
    .b2_i  (tx_b2_i),
    .d_i   (tx_d_i),
    .aux_i (tx_aux_i),
    .req_o (tx_req_o),
    .pos_o (line_pos_o),
    .neg_o (line_neg_o)
  );

  sbus_rx_deframer #(
    .LOCK_HITS  (LOCK_HITS),
    .LOSS_MISSES(LOSS_MISSES),
    .GAP_MIN    (GAP_MIN)
  ) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pos_i  (line_pos_i),
    .neg_i  (line_neg_i),
    .b1_o   (rx_b1_o),
    .b2_o   (rx_b2_o),
    .d_o    (rx_d_o),
    .valid_o(rx_valid_o),
    .lock_o (rx_lock_o),
    .err_o  (rx_err_o)
  );
endmodule

// File: tb/sbus_frame_codec_bench.sv
module sbus_frame_codec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tx_b1 = '0, tx_b2 = '0;
  logic [3:0]  tx_d = '0;
  logic [7:0]  tx_aux = '0;
  logic        tx_req, lpos_o, lneg_o, lpos_i, lneg_i;
  logic [15:0] rx_b1, rx_b2;
  logic [3:0]  rx_d;
  logic        rx_valid, rx_lock, rx_err;
  logic        inj_en = 1'b0, inj_pos = 1'b0, inj_neg = 1'b0;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign lpos_i = inj_en ? inj_pos : lpos_o;
  assign lneg_i = inj_en ? inj_neg : lneg_o;

  sbus_frame_codec u_sbus_frame_codec (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_b1_i(tx_b1), .tx_b2_i(tx_b2), .tx_d_i(tx_d), .tx_aux_i(tx_aux),
    .tx_req_o(tx_req), .line_pos_o(lpos_o), .line_neg_o(lneg_o),
    .line_pos_i(lpos_i), .line_neg_i(lneg_i),
    .rx_b1_o(rx_b1), .rx_b2_o(rx_b2), .rx_d_o(rx_d),
    .rx_valid_o(rx_valid), .rx_lock_o(rx_lock), .rx_err_o(rx_err)
  );

  // bench model state
  logic [47:0] m_fv, m_next_fv;
  logic        ld_pend = 1'b0, m_last = 1'b0, m_pnd = 1'b0;
  int          bpos = -1, nsent = 0, nvalid = 0;
  bit          skip = 0;
  logic [15:0] h_b1 [128];
  logic [15:0] h_b2 [128];
  logic [3:0]  h_d  [128];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected frame layout, written from the requirement table
  function automatic logic [47:0] layout(input logic [15:0] b1, input logic [15:0] b2,
                                         input logic [3:0] d, input logic [7:0] aux);
    logic [47:0] v;
    int zeros;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      v[2+i]  = b1[15-i]; v[26+i] = b1[7-i];
      v[15+i] = b2[15-i]; v[37+i] = b2[7-i];
    end
    v[10] = aux[7]; v[11] = d[3]; v[12] = aux[3]; v[13] = aux[2]; v[14] = !aux[2];
    v[23] = aux[6]; v[24] = d[2]; v[25] = aux[1];
    v[34] = aux[5]; v[35] = d[1]; v[36] = aux[0];
    v[45] = aux[4]; v[46] = d[0];
    zeros = 0;
    for (int i = 2; i <= 46; i++) if (!v[i]) zeros++;
    v[47] = (zeros % 2 == 1) ? 1'b0 : 1'b1;
    return v;
  endfunction

  task automatic load_next();
    int k;
    k = nsent;
    case (k % 4)
      0: begin tx_b1 = '1; tx_b2 = '1; tx_d = '1; tx_aux = '1; end
      1: begin tx_b1 = '0; tx_b2 = '0; tx_d = '0; tx_aux = '0; end
      2: begin tx_b1 = 16'(k * 40503) ^ 16'h5a3c; tx_b2 = ~16'(k * 7919);
               tx_d = 4'(k); tx_aux = 8'(k * 37); end
      default: begin tx_b1 = 16'(k * 2731) ^ 16'h8001; tx_b2 = 16'(k * 613) | 16'h0100;
               tx_d = 4'(~k); tx_aux = 8'(k * 91) ^ 8'h24; end
    endcase
    h_b1[k % 128] = tx_b1; h_b2[k % 128] = tx_b2; h_d[k % 128] = tx_d;
    m_next_fv = layout(tx_b1, tx_b2, tx_d, tx_aux);
    ld_pend = 1'b1;
    nsent++;
  endtask

  task automatic tick();
    logic em, ep;
    int   cur;
    @(negedge clk);
    if (ld_pend) begin bpos = 0; m_fv = m_next_fv; ld_pend = 1'b0; end
    else if (bpos >= 0 && bpos < 47) bpos++;
    cur = nsent - 1;
    // R1
    chk(!(lpos_o && lneg_o), "R1", "both marks", {lpos_o, lneg_o}, 2'b00);
    if (bpos >= 0) begin
      em = (bpos == 0) ? 1'b1 : !m_fv[bpos];
      if (bpos == 0 || m_pnd) ep = m_last;
      else                    ep = !m_last;
      if (em && bpos != 0) m_last = ep;
      if (bpos == 1) m_pnd = 1'b1;
      else if (em)   m_pnd = 1'b0;
      if ((lpos_o || lneg_o) != em)
        chk(0, (bpos == 0) ? "R4" : (bpos == 1 || bpos == 47) ? "R5" : (bpos == 14) ? "R6" : "R3",
            $sformatf("mark at bit %0d", bpos), lpos_o | lneg_o, em);
      else if (em)
        chk(lpos_o == ep, (bpos == 0) ? "R4" : "R2", $sformatf("polarity at bit %0d", bpos), lpos_o, ep);
      else
        chk(1, "R1", "space", 0, 0);
      // R7
      chk(tx_req == (bpos == 47), "R7", $sformatf("request at bit %0d", bpos), tx_req, bpos == 47);
      // R8 R12: lock on the third frame start, not on the second violation
      if (cur == 3 && bpos == 0) chk(!rx_lock, "R8", "lock before third start", rx_lock, 0);
      if (cur == 3 && bpos == 1) chk(rx_lock, "R12", "lock after third start", rx_lock, 1);
    end
    if (!skip && !inj_en) chk(!rx_err, "R11", "spurious error", rx_err, 0);
    if (rx_valid && !skip) begin
      int j;
      j = (nsent - 2) % 128;
      nvalid++;
      // R10
      chk({rx_b1, rx_b2, rx_d} == {h_b1[j], h_b2[j], h_d[j]}, "R10", "received frame",
          {rx_b1, rx_b2, rx_d}, {h_b1[j], h_b2[j], h_d[j]});
    end
    if (tx_req) load_next();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({lpos_o, lneg_o, rx_lock, rx_valid, rx_err} == 5'b0, "R7", "reset outputs",
        {lpos_o, lneg_o, rx_lock, rx_valid, rx_err}, 0);
    chk(tx_req, "R7", "request in reset", tx_req, 1);
    rst_n = 1'b1;
    load_next();
    // clean loopback
    repeat (12 * 48) tick();
    chk(rx_lock, "R8", "lock held", rx_lock, 1);
    // silence the line
    while (bpos != 5) tick();
    inj_en = 1'b1; inj_pos = 1'b0; inj_neg = 1'b0; skip = 1;
    repeat (96) tick();
    chk(rx_lock, "R9", "lock after two missed starts", rx_lock, 1);
    repeat (48) tick();
    chk(!rx_lock, "R9", "lock after three missed starts", rx_lock, 0);
    inj_en = 1'b0;
    repeat (5 * 48) tick();
    chk(rx_lock, "R12", "relock after silence", rx_lock, 1);
    skip = 0;
    repeat (2 * 48) tick();
    // misplaced violation inside an idle B2 field
    while (!(bpos == 20 && ((nsent - 1) % 4 == 0))) tick();
    skip = 1;
    inj_en = 1'b1; inj_pos = m_last; inj_neg = !m_last;
    tick();
    inj_en = 1'b0;
    chk(rx_err, "R11", "misplaced violation", rx_err, 1);
    tick();
    chk(!rx_err, "R11", "error pulse width", rx_err, 0);
    repeat (2 * 48) tick();
    skip = 0;
    chk(rx_lock, "R11", "lock kept after error", rx_lock, 1);
    repeat (3 * 48) tick();
    chk(nvalid > 10, "R10", "frames delivered", nvalid, 11);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule